// File: doc/BRIEF.md
# Pipeline Timing-Error Recovery Controller

This block steers recovery in a five-stage in-order pipeline whose stage registers can report a late-arriving (timing) error. Stages are numbered 0 to 4: 0 is fetch, 1 decode, 2 execute, 3 memory access (read-only) and 4 writeback. Writeback is the only stage that changes the register file or memory. Each cycle the pipeline presents, for every stage, a valid bit, an error flag, an instruction tag and the instruction's PC.

When a live stage flags an error, its result is voided. An error marker then travels down the pipeline in place of that result, one stage per cycle. A recover indication starts at the faulting stage and walks back toward fetch, one hop per cycle, so each stage only has to talk to its neighbour. A single flush controller picks the oldest faulting instruction. In the next cycle it issues a flush carrying that instruction's tag, a squash mask covering that stage and every younger stage, and a fetch redirect to the faulting instruction's own PC, so that instruction runs again. This is the same kind of squash-and-redirect used for a branch misprediction, and the cost is the refill time.

All control pins are plain level signals with no handshake. The block never stalls: the pipeline is taken to advance by one stage every cycle, and no pin provides back-pressure.

Top module: `pipe_err_recovery`

## Requirements
- R1: While reset is held and after it is released, all registered outputs are zero: flush_o, flush_tag_o, redirect_pc_o, squash_o, bubble_o and recover_o.
- R2: A stage s below 4 is live when it is valid, holds no bubble and is not being squashed in the current cycle. When such a stage flags an error, bubble_o bit s+1 is high in the next cycle. That bubble then moves up one bit per cycle and drops off after stage 4.
- R3: One cycle after live stage s flags an error, recover_o bit s is high. Each set recover bit moves to the next lower stage index every cycle and leaves after stage 0.
- R4: One cycle after any live stage flags an error, flush_o is high for one cycle. At the same time flush_tag_o and redirect_pc_o give the tag and PC of the chosen stage.
- R5: When several live stages flag errors in the same cycle, the stage with the highest index (the oldest instruction) is chosen.
- R6: While flush_o is high, squash_o bit k is high exactly for every k at or below the chosen stage index. While flush_o is low, squash_o is zero.
- R7: An error flag causes no bubble, recover or flush when its stage is not valid, when that stage holds a bubble, or when that stage is being squashed in the current cycle.
- R8: commit_o is high only when stage 4 is valid, holds no bubble, has no error flag and is not being squashed.
- R9: A bubble in a stage that is squashed in the current cycle is removed and does not move on to the next stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_valid_i | input | NSTG | Per-stage instruction valid, bit = stage index |
| stg_err_i | input | NSTG | Per-stage timing-error flag |
| stg_tag_i | input | NSTG*TAG_W | Per-stage instruction tag, stage s at bits [s*TAG_W +: TAG_W] |
| stg_pc_i | input | NSTG*PC_W | Per-stage instruction PC, stage s at bits [s*PC_W +: PC_W] |
| bubble_o | output | NSTG | Stage currently holds an error bubble |
| recover_o | output | NSTG | Local recover indication per stage |
| squash_o | output | NSTG | Stages to squash during a flush |
| flush_o | output | 1 | Flush request |
| flush_tag_o | output | TAG_W | Tag of the oldest faulting instruction |
| redirect_pc_o | output | PC_W | Fetch restart address |
| commit_o | output | 1 | Writeback may update architectural state |

## Verification
The tests use four error patterns:
- A single error in the middle of the pipeline shows whether bubbles move toward writeback and recover bits move toward fetch, each one hop per cycle, and whether the flush names the right tag and PC.
- Two errors in the same cycle separate oldest-first selection from youngest-first selection. They also show whether a bubble inside the squash range is dropped while one outside it survives.
- Errors on invalid stages, on a stage that holds a bubble, and on a stage being squashed check that stale flags are masked.
- An error in writeback checks the full-width squash and the commit gating, which is also tested against a plain valid/invalid writeback.

// File: rtl/pipe_rec_pkg.sv
package pipe_rec_pkg;
  // Stage numbering used throughout; the order is behaviour (older = higher).
  typedef enum logic [2:0] {
    STG_FETCH  = 3'd0,
    STG_DECODE = 3'd1,
    STG_EXEC   = 3'd2,
    STG_MEMRD  = 3'd3,
    STG_WBACK  = 3'd4
  } stage_e;
  localparam int unsigned STAGE_COUNT = 5;
endpackage

// File: rtl/rec_oldest_sel.sv
module rec_oldest_sel #(
  parameter int unsigned NSTG  = 5,
  parameter int unsigned IDX_W = $clog2(NSTG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTG-1:0]  hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NSTG-1:0]  oh_o
);
  // Highest index wins: later loop iterations overwrite earlier ones.
  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (hit_i[s]) begin
        idx_o = IDX_W'(s);
        oh_o  = '0;
        oh_o[s] = 1'b1;
      end
    end
  end
  assign any_o = |hit_i;

  a_r5_single_pick : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oh_o));
  a_r5_pick_is_hit : assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> hit_i[idx_o]);
endmodule

// File: rtl/rec_flush_ctl.sv
module rec_flush_ctl #(
  parameter int unsigned NSTG  = 5,
  parameter int unsigned IDX_W = $clog2(NSTG),
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [NSTG*TAG_W-1:0] tag_i,
  input  logic [NSTG*PC_W-1:0]  pc_i,
  output logic              flush_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [NSTG-1:0]   squash_o
);
  logic [NSTG-1:0] squash_d;

  always_comb begin
    for (int k = 0; k < NSTG; k++)
      squash_d[k] = any_i && (IDX_W'(k) <= idx_i);
  end

  // Registered so the redirect address is stable for the whole flush cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_o  <= 1'b0;
      tag_o    <= '0;
      pc_o     <= '0;
      squash_o <= '0;
    end else begin
      flush_o  <= any_i;
      squash_o <= squash_d;
      if (any_i) begin
        tag_o <= tag_i[idx_i*TAG_W +: TAG_W];
        pc_o  <= pc_i[idx_i*PC_W +: PC_W];
      end
    end
  end

  a_r6_quiet_mask : assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |-> (squash_o == '0));
  a_r6_from_fetch : assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (squash_o[0] && (((squash_o + 1'b1) & squash_o) == '0)));
endmodule

// File: rtl/rec_local_track.sv
module rec_local_track #(
  parameter int unsigned NSTG = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] hit_i,
  input  logic            flush_i,
  input  logic [NSTG-1:0] squash_i,
  output logic [NSTG-1:0] bub_o,
  output logic [NSTG-1:0] rec_o
);
  logic [NSTG-1:0] kill;
  logic [NSTG-1:0] bub_d;
  logic [NSTG-1:0] rec_d;

  assign kill = squash_i & {NSTG{flush_i}};

  // Bubbles move toward writeback, recover moves toward fetch.
  assign bub_d[0]      = 1'b0;
  assign rec_d[NSTG-1] = hit_i[NSTG-1];
  for (genvar s = 0; s < NSTG - 1; s++) begin : g_hop
    assign bub_d[s+1] = (hit_i[s] | bub_o[s]) & ~kill[s];
    assign rec_d[s]   = hit_i[s] | rec_o[s+1];

    a_r2_bubble_moves : assert property (@(posedge clk) disable iff (!rst_n)
      (bub_o[s] && !kill[s]) |=> bub_o[s+1]);
    a_r9_bubble_killed : assert property (@(posedge clk) disable iff (!rst_n)
      (kill[s] && !hit_i[s]) |=> !bub_o[s+1]);
    a_r3_recover_hop : assert property (@(posedge clk) disable iff (!rst_n)
      rec_o[s+1] |=> rec_o[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bub_o <= '0;
      rec_o <= '0;
    end else begin
      bub_o <= bub_d;
      rec_o <= rec_d;
    end
  end
endmodule

// File: rtl/pipe_err_recovery.sv
module pipe_err_recovery #(
  parameter int unsigned NSTG  = 5,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PC_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSTG-1:0]       stg_valid_i,
  input  logic [NSTG-1:0]       stg_err_i,
  input  logic [NSTG*TAG_W-1:0] stg_tag_i,
  input  logic [NSTG*PC_W-1:0]  stg_pc_i,
  output logic [NSTG-1:0]       bubble_o,
  output logic [NSTG-1:0]       recover_o,
  output logic [NSTG-1:0]       squash_o,
  output logic                  flush_o,
  output logic [TAG_W-1:0]      flush_tag_o,
  output logic [PC_W-1:0]       redirect_pc_o,
  output logic                  commit_o
);
  localparam int unsigned IDX_W = $clog2(NSTG);
  localparam int unsigned LAST  = NSTG - 1;

  logic [NSTG-1:0]  live;
  logic [NSTG-1:0]  hit;
  logic             any_hit;
  logic [IDX_W-1:0] pick_idx;
  logic [NSTG-1:0]  pick_oh;

  // A stage counts only if it holds a real instruction not already doomed.
  assign live = stg_valid_i & ~bubble_o & ~(squash_o & {NSTG{flush_o}});
  assign hit  = stg_err_i & live;

  rec_oldest_sel #(.NSTG(NSTG), .IDX_W(IDX_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_i (hit),
    .any_o (any_hit),
    .idx_o (pick_idx),
    .oh_o  (pick_oh)
  );

  rec_flush_ctl #(.NSTG(NSTG), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_i    (any_hit),
    .idx_i    (pick_idx),
    .tag_i    (stg_tag_i),
    .pc_i     (stg_pc_i),
    .flush_o  (flush_o),
    .tag_o    (flush_tag_o),
    .pc_o     (redirect_pc_o),
    .squash_o (squash_o)
  );

  rec_local_track #(.NSTG(NSTG)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit),
    .flush_i  (flush_o),
    .squash_i (squash_o),
    .bub_o    (bubble_o),
    .rec_o    (recover_o)
  );

  // Only clean writeback work may update architectural state.
  assign commit_o = live[LAST] & ~stg_err_i[LAST];

  a_r8_no_bubble_commit : assert property (@(posedge clk) disable iff (!rst_n)
    (bubble_o[LAST] || stg_err_i[LAST]) |-> !commit_o);
  a_r4_flush_follows : assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> flush_o);
  a_r4_flush_cause : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_o) |-> $past(|(stg_err_i & stg_valid_i)));
  a_r5_oldest_squashed : assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> squash_o[$past(pick_idx)]);
  a_r1_quiet_start : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!flush_o && bubble_o == '0));
endmodule

// File: tb/pipe_err_recovery_tb_top.sv
`timescale 1ns/1ps
module pipe_err_recovery_tb_top;
  import pipe_rec_pkg::*;
  localparam int unsigned NSTG  = STAGE_COUNT;
  localparam int unsigned TAG_W = 6;
  localparam int unsigned PC_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSTG-1:0]       v, e;
  logic [NSTG*TAG_W-1:0] tg;
  logic [NSTG*PC_W-1:0]  pc;
  logic [NSTG-1:0] bubble, recover, squash;
  logic flush, commit;
  logic [TAG_W-1:0] ftag;
  logic [PC_W-1:0]  rpc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pipe_err_recovery #(.NSTG(NSTG), .TAG_W(TAG_W), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .stg_valid_i(v), .stg_err_i(e),
    .stg_tag_i(tg), .stg_pc_i(pc), .bubble_o(bubble), .recover_o(recover),
    .squash_o(squash), .flush_o(flush), .flush_tag_o(ftag),
    .redirect_pc_o(rpc), .commit_o(commit));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Tag of stage s is base+s; PC is 0x100 + base*16 + s*4.
  task automatic setin(input logic [NSTG-1:0] vv, input logic [NSTG-1:0] ee, input int base);
    v = vv; e = ee;
    for (int s = 0; s < NSTG; s++) begin
      tg[s*TAG_W +: TAG_W] = TAG_W'(base + s);
      pc[s*PC_W +: PC_W]   = PC_W'(16'h100 + base*16 + s*4);
    end
    #1;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic drain;
    setin('0, '0, 0);
    repeat (7) tick();
  endtask

  task automatic t_reset;
    setin('0, '0, 0);
    eq("R1 flush in reset", flush, 0);
    eq("R1 squash in reset", squash, 0);
    repeat (2) tick();
    rst_n = 1'b1;
    tick(); tick();
    eq("R1 bubble", bubble, 0);
    eq("R1 recover", recover, 0);
    eq("R1 flush", flush, 0);
    eq("R1 tag", ftag, 0);
    eq("R1 redirect", rpc, 0);
    eq("R1 squash", squash, 0);
  endtask

  task automatic t_single;
    setin(5'h1F, 5'b00100, 0);
    tick();
    eq("R2 bubble after EX error", bubble, 5'b01000);
    eq("R3 recover at EX", recover, 5'b00100);
    eq("R4 flush", flush, 1);
    eq("R4 tag", ftag, 2);
    eq("R4 redirect pc", rpc, 16'h108);
    eq("R6 squash", squash, 5'b00111);
    setin(5'h1F, '0, 0);
    tick();
    eq("R2 bubble moved to WB", bubble, 5'b10000);
    eq("R3 recover hop", recover, 5'b00010);
    eq("R4 flush single cycle", flush, 0);
    eq("R6 squash cleared", squash, 0);
    eq("R8 bubble in WB blocks commit", commit, 0);
    tick();
    eq("R2 bubble leaves", bubble, 0);
    eq("R3 recover at fetch", recover, 5'b00001);
    eq("R8 clean WB commits", commit, 1);
    tick();
    eq("R3 recover gone", recover, 0);
    drain();
  endtask

  task automatic t_multi;
    setin(5'h1F, 5'b01010, 16);
    tick();
    eq("R5 oldest tag", ftag, 19);
    eq("R5 oldest pc", rpc, 16'h20C);
    eq("R6 squash to MEM", squash, 5'b01111);
    eq("R2 two bubbles", bubble, 5'b10100);
    eq("R3 two recovers", recover, 5'b01010);
    setin(5'h1F, '0, 16);
    eq("R8 WB bubble no commit", commit, 0);
    tick();
    eq("R9 squashed bubble removed", bubble, 0);
    eq("R3 recovers hop", recover, 5'b00101);
    drain();
  endtask

  task automatic t_ignore;
    setin(5'b11011, 5'b00100, 32);
    tick();
    eq("R7 invalid stage no flush", flush, 0);
    eq("R7 invalid stage no bubble", bubble, 0);
    eq("R7 invalid stage no recover", recover, 0);
    setin(5'h1F, 5'b00010, 32);
    tick();
    eq("R4 decode tag", ftag, 33);
    eq("R2 bubble at EX", bubble, 5'b00100);
    // stage 2 holds a bubble, stage 0 is being squashed
    setin(5'h1F, 5'b00101, 32);
    tick();
    eq("R7 masked errors no flush", flush, 0);
    eq("R7 masked errors bubble only moves", bubble, 5'b01000);
    eq("R7 masked errors recover", recover, 5'b00001);
    drain();
  endtask

  task automatic t_wb;
    setin(5'h1F, 5'b10000, 40);
    eq("R8 WB error no commit", commit, 0);
    tick();
    eq("R4 WB tag", ftag, 44);
    eq("R4 WB redirect", rpc, 16'h390);
    eq("R6 squash all", squash, 5'b11111);
    eq("R2 no bubble from WB", bubble, 0);
    setin(5'h1F, '0, 40);
    eq("R8 squashed WB no commit", commit, 0);
    tick();
    eq("R3 WB recover hop", recover, 5'b01000);
    drain();
  endtask

  task automatic t_commit;
    setin(5'b01111, '0, 0);
    eq("R8 invalid WB no commit", commit, 0);
    setin(5'h1F, '0, 0);
    eq("R8 valid WB commits", commit, 1);
    drain();
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_ignore();
    t_wb();
    t_commit();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule